// File: doc/BRIEF.md
# Four-Layer Configuration Context Store

This block holds the configuration of one coarse-grained processing element, or of a small group of elements that share a configuration bus. It keeps four complete configuration layers. The word the datapath sees comes from the active layer, and a context-select request makes a different layer active on the next clock edge. A bank-select output follows the active layer, so that a layered register file beside the datapath switches in step with the configuration and nothing has to be saved.

A host fills the layers over a shared, write-only bus. Each write uses two 32-bit words. The first is an address word, flagged by `bus_is_addr`, that names the element, the layer and the word offset. The second is the data word. Only the element whose strapped identifier matches accepts the write. Any layer may be written while the datapath runs. A write to the active layer goes into that layer's backing store only. It reaches the datapath at the next context switch into that layer, so the running configuration never changes under the datapath.

Top module: `cfg_context_store`

## Requirements
- R1: After reset, `bank_sel` is 0, `ctx_ack` is 0, and every word of every layer, including the word on `cfg_word`, reads as 0.
- R2: A bus word with `bus_is_addr`=1 is an address word. Its bits [31:16] are the element identifier, bits [15:14] the layer and bits [7:0] the word offset. When the identifier equals `my_id`, the next bus word with `bus_is_addr`=0 is stored at that layer and offset.
- R3: An address word whose identifier differs from `my_id` cancels any pending write, and the data word after it is not stored.
- R4: A data word with no pending address is dropped. One address word permits exactly one data write, so a second data word after it is dropped.
- R5: A second matching address word replaces the pending one. The data word that follows goes only to the second address.
- R6: Bits [13:8] of an address word have no effect.
- R7: A write whose offset is DEPTH or higher is dropped, and it does not alias onto a lower word.
- R8: When `ctx_req`=1 at a clock edge, `bank_sel` takes `ctx_sel` from that edge on. `cfg_word` then shows the contents of that layer, including a write that lands at the same edge.
- R9: `ctx_ack` is high for exactly the one cycle after each edge at which `ctx_req` was sampled high.
- R10: A write to the active layer leaves `cfg_word` unchanged until the next switch into that layer, including a switch to the layer that is already active.
- R11: A write to an idle layer leaves `cfg_word` unchanged.
- R12: `bank_sel` holds its value at every edge where `ctx_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_id | input | 16 | Strapped element identifier |
| bus_valid | input | 1 | A bus word is present this cycle |
| bus_is_addr | input | 1 | 1: address word, 0: data word |
| bus_word | input | 32 | Configuration bus word |
| ctx_req | input | 1 | Context switch request |
| ctx_sel | input | 2 | Layer to make active |
| rd_idx | input | $clog2(DEPTH) | Word index the datapath reads |
| cfg_word | output | 32 | Active configuration word at `rd_idx` |
| bank_sel | output | 2 | Active layer, which also selects the register-file bank |
| ctx_ack | output | 1 | One-cycle acknowledge of a switch |

## Verification
The assertions check every cycle that a request moves `bank_sel` and raises a single acknowledge, that `bank_sel` holds when there is no request, and that `cfg_word` at a steady index stays frozen between switches whatever the bus carries. Only the bench scenarios can show which words end up in which layer. These cover identifier filtering, dropped orphan data, replacement of a pending address, ignored reserved bits and rejected out-of-range offsets, each made visible by switching to the layer afterwards and reading it back.

// File: rtl/cfgctx_pkg.sv
package cfgctx_pkg;
    localparam int WORD_W    = 32;
    localparam int ID_W      = 16;
    localparam int LAYER_W   = 2;
    localparam int OFF_W     = 8;
    localparam int LAYERS    = 1 << LAYER_W;
    // field positions inside an address word
    localparam int ID_LSB    = 16;
    localparam int LAYER_LSB = 14;
    localparam int OFF_LSB   = 0;

    typedef logic [LAYER_W-1:0] layer_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [WORD_W-1:0]  word_t;
endpackage

// File: rtl/cfgctx_bus_decoder.sv
module cfgctx_bus_decoder
    import cfgctx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     my_id,
    input  logic                bus_valid,
    input  logic                bus_is_addr,
    input  word_t               bus_word,
    output logic                wr_en,
    output layer_t              wr_layer,
    output off_t                wr_off,
    output word_t               wr_data
);
    typedef struct packed {
        logic   pend;
        layer_t layer;
        off_t   off;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_valid) begin
            if (bus_is_addr) begin
                st_d.pend  = (bus_word[ID_LSB +: ID_W] == my_id);
                st_d.layer = bus_word[LAYER_LSB +: LAYER_W];
                st_d.off   = bus_word[OFF_LSB +: OFF_W];
            end else begin
                st_d.pend  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en    = bus_valid && !bus_is_addr && st_q.pend;
    assign wr_layer = st_q.layer;
    assign wr_off   = st_q.off;
    assign wr_data  = bus_word;
endmodule

// File: rtl/cfgctx_switch.sv
module cfgctx_switch
    import cfgctx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ctx_req,
    input  layer_t ctx_sel,
    output logic   load_en,
    output layer_t load_layer,
    output layer_t active,
    output logic   ack
);
    typedef struct packed {
        layer_t act;
        logic   ack;
    } sw_t;

    sw_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = ctx_req;
        if (ctx_req) st_d.act = ctx_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_en    = ctx_req;
    assign load_layer = ctx_sel;
    assign active     = st_q.act;
    assign ack        = st_q.ack;
endmodule

// File: rtl/cfgctx_layer_store.sv
module cfgctx_layer_store
    import cfgctx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  layer_t           wr_layer,
    input  off_t             wr_off,
    input  word_t            wr_data,
    input  logic             load_en,
    input  layer_t           load_layer,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word
);
    typedef struct packed {
        logic [LAYERS-1:0][DEPTH-1:0][WORD_W-1:0] bank;
        logic [DEPTH-1:0][WORD_W-1:0]             work;
    } store_t;

    store_t st_d, st_q;
    logic   in_range;

    assign in_range = (int'(wr_off) < DEPTH);

    always_comb begin
        st_d = st_q;
        if (wr_en && in_range)
            st_d.bank[wr_layer][wr_off[IDX_W-1:0]] = wr_data;
        // the working copy takes the layer including a same-edge write
        if (load_en)
            st_d.work = st_d.bank[load_layer];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word = st_q.work[rd_idx];
endmodule

// File: rtl/cfg_context_store.sv
module cfg_context_store
    import cfgctx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      my_id,
    input  logic             bus_valid,
    input  logic             bus_is_addr,
    input  logic [31:0]      bus_word,
    input  logic             ctx_req,
    input  logic [1:0]       ctx_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      cfg_word,
    output logic [1:0]       bank_sel,
    output logic             ctx_ack
);
    logic   wr_en, load_en;
    layer_t wr_layer, load_layer;
    off_t   wr_off;
    word_t  wr_data;

    cfgctx_bus_decoder u_dec (
        .clk, .rst_n, .my_id, .bus_valid, .bus_is_addr, .bus_word,
        .wr_en, .wr_layer, .wr_off, .wr_data
    );

    cfgctx_switch u_sw (
        .clk, .rst_n, .ctx_req, .ctx_sel,
        .load_en, .load_layer, .active(bank_sel), .ack(ctx_ack)
    );

    cfgctx_layer_store #(.DEPTH(DEPTH)) u_store (
        .clk, .rst_n, .wr_en, .wr_layer, .wr_off, .wr_data,
        .load_en, .load_layer, .rd_idx, .rd_word(cfg_word)
    );
endmodule

// File: rtl/cfg_context_store_chk.sv
module cfg_context_store_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctx_req,
    input logic [1:0]       ctx_sel,
    input logic [IDX_W-1:0] rd_idx,
    input logic [31:0]      cfg_word,
    input logic [1:0]       bank_sel,
    input logic             ctx_ack
);
    // R8
    switch_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_req |=> (bank_sel == $past(ctx_sel)));
    // R9
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_req |=> ctx_ack);
    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_req |=> !ctx_ack);
    // R12
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_req |=> $stable(bank_sel));
    // R10
    word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_req |=> ($stable(rd_idx) -> $stable(cfg_word)));
endmodule

bind cfg_context_store cfg_context_store_chk #(.IDX_W(IDX_W)) u_chk (
    .clk, .rst_n, .ctx_req, .ctx_sel, .rd_idx, .cfg_word, .bank_sel, .ctx_ack
);

// File: tb/cfg_context_store_tb.sv
module cfg_context_store_tb;
    localparam int DEPTH = 16;
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [15:0] ME    = 16'h5A3C;
    localparam logic [15:0] OTHER = 16'h1234;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0, bus_is_addr = 1'b0, ctx_req = 1'b0;
    logic [31:0]      bus_word = '0;
    logic [1:0]       ctx_sel = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [31:0]      cfg_word;
    logic [1:0]       bank_sel;
    logic             ctx_ack;
    int               n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    cfg_context_store #(.DEPTH(DEPTH)) u_dut (
        .clk, .rst_n, .my_id(ME), .bus_valid, .bus_is_addr, .bus_word,
        .ctx_req, .ctx_sel, .rd_idx, .cfg_word, .bank_sel, .ctx_ack
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic is_a, input logic [31:0] w);
        @(negedge clk);
        bus_valid = 1'b1; bus_is_addr = is_a; bus_word = w;
        @(negedge clk);
        bus_valid = 1'b0; bus_is_addr = 1'b0; bus_word = '0;
    endtask

    function automatic logic [31:0] aw(input logic [15:0] id, input logic [1:0] l,
                                       input logic [5:0] rsv, input logic [7:0] off);
        return {id, l, rsv, off};
    endfunction

    task automatic switch_to(input logic [1:0] l, input string req);
        @(negedge clk);
        ctx_req = 1'b1; ctx_sel = l;
        @(posedge clk); #1;
        chk(req, {31'd0, ctx_ack}, 32'd1);
        chk(req, {30'd0, bank_sel}, {30'd0, l});
        @(negedge clk);
        ctx_req = 1'b0;
        @(posedge clk); #1;
        chk("R9", {31'd0, ctx_ack}, 32'd0);
    endtask

    task automatic read(input int idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        #1;
        chk(req, cfg_word, exp);
    endtask

    task automatic t_reset;
        chk("R1", {30'd0, bank_sel}, 32'd0);
        chk("R1", {31'd0, ctx_ack}, 32'd0);
        read(0, 32'd0, "R1");
        read(9, 32'd0, "R1");
    endtask

    task automatic t_basic;
        send(1'b1, aw(ME, 2'd1, 6'd0, 8'd3));
        send(1'b0, 32'hA1A1_0003);
        switch_to(2'd1, "R8");
        read(3, 32'hA1A1_0003, "R2");
        read(2, 32'd0, "R2");
    endtask

    task automatic t_foreign;
        send(1'b1, aw(ME, 2'd1, 6'd0, 8'd4));
        send(1'b1, aw(OTHER, 2'd1, 6'd0, 8'd4));
        send(1'b0, 32'hBBBB_0004);
        switch_to(2'd1, "R8");
        read(4, 32'd0, "R3");
    endtask

    task automatic t_orphan;
        send(1'b0, 32'hDEAD_0000);
        send(1'b1, aw(ME, 2'd2, 6'd0, 8'd0));
        send(1'b0, 32'hC0C0_0000);
        send(1'b0, 32'hD0D0_0000);
        switch_to(2'd2, "R8");
        read(0, 32'hC0C0_0000, "R4");
    endtask

    task automatic t_replace;
        send(1'b1, aw(ME, 2'd2, 6'd0, 8'd1));
        send(1'b1, aw(ME, 2'd2, 6'd0, 8'd2));
        send(1'b0, 32'hEEEE_0002);
        switch_to(2'd2, "R8");
        read(1, 32'd0, "R5");
        read(2, 32'hEEEE_0002, "R5");
    endtask

    task automatic t_reserved;
        send(1'b1, aw(ME, 2'd3, 6'h3F, 8'd5));
        send(1'b0, 32'hF5F5_0005);
        switch_to(2'd3, "R8");
        read(5, 32'hF5F5_0005, "R6");
    endtask

    task automatic t_range;
        send(1'b1, aw(ME, 2'd3, 6'd0, 8'(DEPTH)));
        send(1'b0, 32'h6666_0010);
        send(1'b1, aw(ME, 2'd3, 6'd0, 8'(DEPTH + 1)));
        send(1'b0, 32'h6666_0011);
        switch_to(2'd3, "R8");
        read(0, 32'd0, "R7");
        read(1, 32'd0, "R7");
    endtask

    task automatic t_active;
        read(6, 32'd0, "R10");
        send(1'b1, aw(ME, 2'd3, 6'd0, 8'd6));
        send(1'b0, 32'h7777_0006);
        read(6, 32'd0, "R10");
        switch_to(2'd3, "R10");
        read(6, 32'h7777_0006, "R10");
    endtask

    task automatic t_idle;
        read(5, 32'hF5F5_0005, "R11");
        send(1'b1, aw(ME, 2'd0, 6'd0, 8'd5));
        send(1'b0, 32'h1111_0005);
        read(5, 32'hF5F5_0005, "R11");
        switch_to(2'd0, "R8");
        read(5, 32'h1111_0005, "R11");
    endtask

    task automatic t_hold;
        @(negedge clk);
        ctx_sel = 2'd2;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk("R12", {30'd0, bank_sel}, 32'd0);
        end
    endtask

    task automatic t_same_edge;
        // write and switch land on the same edge
        send(1'b1, aw(ME, 2'd1, 6'd0, 8'd7));
        @(negedge clk);
        bus_valid = 1'b1; bus_is_addr = 1'b0; bus_word = 32'h8888_0007;
        ctx_req = 1'b1; ctx_sel = 2'd1;
        @(negedge clk);
        bus_valid = 1'b0; bus_word = '0; ctx_req = 1'b0;
        read(7, 32'h8888_0007, "R8");
        chk("R8", {30'd0, bank_sel}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_foreign();
        t_orphan();
        t_replace();
        t_reserved();
        t_range();
        t_active();
        t_idle();
        t_hold();
        t_same_edge();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule